// File: doc/BRIEF.md
# Fast Pulse Event Detector

This block watches a stream of signed samples from a short triangular fast shaper, one sample per clock, and marks each photon event with a single-cycle strobe. A sample has to rise strictly above a programmable threshold before anything can be declared. Within a pulse the block follows the running maximum. A peak is accepted once the signal has fallen from that maximum by a programmable hysteresis, or once the signal drops back to the threshold or below it, whichever happens first. After a peak is accepted, the block waits for the signal to climb again by the same hysteresis above its running minimum before it will look for another peak.

Two overlapping pulses with a clear dip between them are therefore counted as two events. Pulses that sit closer together than the pair resolution produce no dip of the hysteresis size, so they merge into one event. For each pulse the block also measures the time above threshold in clocks and reports it with a valid strobe when the pulse ends. The dead time is then taken from the real crossings rather than from the shaper setting, and a later stage can reject pulses with slow risetimes. A running event count is kept. The logic is meant for an 80 MHz clock.

Top module: `fast_event_detector`

## Requirements
- R1: A pulse only starts when a sample is strictly greater than `thresh` (signed compare). A pulse whose samples never exceed `thresh` (equal is not enough) gives no event strobe and no duration report.
- R2: The event strobe is asserted for exactly one cycle. It rises on the second rising edge, counting the edge that captures the first sample that is at least `hyst` below the running maximum of the pulse.
- R3: Once a peak is accepted, no further event is declared until the signal climbs at least `hyst` above its running minimum. Two overlapping peaks separated by a dip of at least `hyst` give two strobes, and strobes never fall on consecutive cycles.
- R4: If two peaks are separated by a dip smaller than `hyst`, they merge into a single strobe.
- R5: A pulse that falls back to `thresh` or below before dropping `hyst` from its maximum still gives one strobe. The strobe follows the first sample at or below `thresh`, with the same latency as R2.
- R6: When a pulse ends, `tot_valid` is high for one cycle and `tot_clocks` equals the number of consecutive samples that were above `thresh`. This report appears with the same latency as R2, counted from the first sample at or below `thresh`, and never on consecutive cycles.
- R7: The duration count saturates at 2^DUR_W-1, which is 255 by default.
- R8: `event_count` increases by exactly one in the same cycle as each strobe and holds otherwise.
- R9: A synchronous active-high `rst` clears the event count, the duration count, the strobes and the sample register, and leaves the detector ready to find a peak. A pulse already above threshold when reset is released is measured only from the samples that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | SAMPLE_W | Signed fast-shaped sample, one per clock |
| thresh | input | SAMPLE_W | Signed fast threshold |
| hyst | input | SAMPLE_W | Unsigned peak hysteresis |
| event_strobe | output | 1 | One-cycle strobe per detected event |
| event_count | output | CNT_W | Running number of events, wraps |
| tot_valid | output | 1 | Duration report valid, one cycle |
| tot_clocks | output | DUR_W | Clocks above threshold for the pulse that just ended |

## Verification
The input patterns are a lone triangle, a triangle peaking exactly at the threshold, two overlapping triangles whose dip is larger than the hysteresis, and the same pair with a dip smaller than it. Together these separate a correct strict compare, correct re-arming and correct merging from off-by-one and missed-dip faults. A low pulse that leaves through the threshold before any hysteresis drop exercises the second way a peak can end. A plateau longer than 255 samples shows the saturation of the duration count. The strobe cycle and the report cycle are checked exactly against the sample index, and the running count is checked across scenarios and across a reset issued in the middle of a pulse.

// File: rtl/fed_pkg.sv
package fed_pkg;
  // Peak tracker phase: hunting for a maximum, or in a valley after a peak
  typedef enum logic {
    TRK_HUNT   = 1'b0,
    TRK_VALLEY = 1'b1
  } trk_state_e;

  // Saturating increment helper for duration counters
  function automatic logic [15:0] sat_inc16(input logic [15:0] v, input logic [15:0] lim);
    return (v >= lim) ? lim : v + 16'd1;
  endfunction
endpackage

// File: rtl/fed_input_stage.sv
module fed_input_stage #(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  input  logic signed [SAMPLE_W-1:0] thresh,
  output logic signed [SAMPLE_W-1:0] sample_q,
  output logic                       above_q
);
  // Register the sample and its threshold comparison together so both
  // downstream units see a consistent view
  always_ff @(posedge clk) begin
    if (rst) begin
      sample_q <= '0;
      above_q  <= 1'b0;
    end else begin
      sample_q <= sample_in;
      above_q  <= (sample_in > thresh);
    end
  end
endmodule

// File: rtl/fed_peak_tracker.sv
module fed_peak_tracker
  import fed_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sample_q,
  input  logic                       above_q,
  input  logic        [SAMPLE_W-1:0] hyst,
  output logic                       fire,
  output logic                       evt_q
);
  localparam int EXT_W = SAMPLE_W + 2;

  trk_state_e                 state_q, state_d;
  logic                       have_max_q, have_max_d;
  logic signed [SAMPLE_W-1:0] run_max_q, run_max_d;
  logic signed [SAMPLE_W-1:0] run_min_q, run_min_d;

  logic signed [EXT_W-1:0] s_x, max_x, min_x, h_x;
  logic                    fall_hit, rise_hit;

  always_comb begin
    s_x      = EXT_W'(sample_q);
    max_x    = EXT_W'(run_max_q);
    min_x    = EXT_W'(run_min_q);
    h_x      = $signed({2'b00, hyst});
    fall_hit = (s_x <= (max_x - h_x));
    rise_hit = (s_x >= (min_x + h_x));
  end

  always_comb begin
    state_d    = state_q;
    have_max_d = have_max_q;
    run_max_d  = run_max_q;
    run_min_d  = run_min_q;
    fire       = 1'b0;
    case (state_q)
      TRK_HUNT: begin
        if (have_max_q && (!above_q || fall_hit)) begin
          fire       = 1'b1;
          state_d    = TRK_VALLEY;
          have_max_d = 1'b0;
          run_min_d  = sample_q;
        end else if (above_q) begin
          have_max_d = 1'b1;
          if (!have_max_q || (sample_q > run_max_q)) run_max_d = sample_q;
        end else begin
          have_max_d = 1'b0;
        end
      end
      default: begin
        if (!above_q) begin
          state_d    = TRK_HUNT;
          have_max_d = 1'b0;
        end else if (rise_hit) begin
          state_d    = TRK_HUNT;
          have_max_d = 1'b1;
          run_max_d  = sample_q;
        end else if (sample_q < run_min_q) begin
          run_min_d  = sample_q;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= TRK_HUNT;
      have_max_q <= 1'b0;
      run_max_q  <= '0;
      run_min_q  <= '0;
      evt_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      have_max_q <= have_max_d;
      run_max_q  <= run_max_d;
      run_min_q  <= run_min_d;
      evt_q      <= fire;
    end
  end
endmodule

// File: rtl/fed_tot_timer.sv
module fed_tot_timer #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             above_q,
  output logic             tot_valid,
  output logic [DUR_W-1:0] tot_clocks
);
  localparam logic [DUR_W-1:0] DUR_MAX = {DUR_W{1'b1}};

  logic [DUR_W-1:0] dur_q;
  logic             pulse_end;

  // A nonzero duration means the previous sample was above threshold
  assign pulse_end = !above_q && (dur_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dur_q      <= '0;
      tot_valid  <= 1'b0;
      tot_clocks <= '0;
    end else begin
      tot_valid <= pulse_end;
      if (pulse_end) tot_clocks <= dur_q;
      if (above_q) begin
        if (dur_q != DUR_MAX) dur_q <= dur_q + 1'b1;
      end else begin
        dur_q <= '0;
      end
    end
  end
endmodule

// File: rtl/fed_event_counter.sv
module fed_event_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  output logic [CNT_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (fire) count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/fast_event_detector.sv
module fast_event_detector #(
  parameter int SAMPLE_W = 16,
  parameter int DUR_W    = 8,
  parameter int CNT_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [SAMPLE_W-1:0] thresh,
  input  logic [SAMPLE_W-1:0] hyst,
  output logic                event_strobe,
  output logic [CNT_W-1:0]    event_count,
  output logic                tot_valid,
  output logic [DUR_W-1:0]    tot_clocks
);
  logic signed [SAMPLE_W-1:0] s_q;
  logic                       above_q;
  logic                       fire;

  fed_input_stage #(.SAMPLE_W(SAMPLE_W)) u_in (
    .clk       (clk),
    .rst       (rst),
    .sample_in ($signed(sample_in)),
    .thresh    ($signed(thresh)),
    .sample_q  (s_q),
    .above_q   (above_q)
  );

  fed_peak_tracker #(.SAMPLE_W(SAMPLE_W)) u_trk (
    .clk      (clk),
    .rst      (rst),
    .sample_q (s_q),
    .above_q  (above_q),
    .hyst     (hyst),
    .fire     (fire),
    .evt_q    (event_strobe)
  );

  fed_tot_timer #(.DUR_W(DUR_W)) u_tot (
    .clk        (clk),
    .rst        (rst),
    .above_q    (above_q),
    .tot_valid  (tot_valid),
    .tot_clocks (tot_clocks)
  );

  fed_event_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .count_q (event_count)
  );
endmodule

// File: rtl/fed_checker.sv
module fed_checker #(
  parameter int DUR_W = 8,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             event_strobe,
  input logic [CNT_W-1:0] event_count,
  input logic             tot_valid,
  input logic [DUR_W-1:0] tot_clocks
);
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    event_strobe |=> !event_strobe); // R3

  AST_TOT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tot_valid |=> !tot_valid); // R6

  AST_TOT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    tot_valid |-> (tot_clocks != '0)); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (event_count == $past(event_count) + CNT_W'(event_strobe))); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (event_count == '0 && !event_strobe && !tot_valid)); // R9
endmodule

bind fast_event_detector fed_checker #(.DUR_W(DUR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .event_strobe (event_strobe),
  .event_count  (event_count),
  .tot_valid    (tot_valid),
  .tot_clocks   (tot_clocks)
);

// File: tb/fast_event_detector_test.sv
module fast_event_detector_test;
  localparam time CLK_PERIOD = 12.5ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sample_in = '0;
  logic [15:0] thresh = 16'd100;
  logic [15:0] hyst = 16'd50;
  logic        event_strobe;
  logic [31:0] event_count;
  logic        tot_valid;
  logic [7:0]  tot_clocks;

  fast_event_detector uut (
    .clk(clk), .rst(rst), .sample_in(sample_in), .thresh(thresh), .hyst(hyst),
    .event_strobe(event_strobe), .event_count(event_count),
    .tot_valid(tot_valid), .tot_clocks(tot_clocks)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  int pat [0:511];
  int plen;
  int n_strobe, first_strobe, second_strobe, n_tot, last_tot, tot_idx;
  int total_events = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drives pat[0..plen-1] then zeros; log index i is observed before driving pat[i].
  // A sample driven at index j affects outputs observed at index j+2.
  task automatic run_pattern();
    n_strobe = 0; first_strobe = -1; second_strobe = -1;
    n_tot = 0; last_tot = -1; tot_idx = -1;
    for (int i = 0; i < plen + 6; i++) begin
      @(negedge clk);
      if (event_strobe) begin
        if (n_strobe == 0) first_strobe = i;
        else if (n_strobe == 1) second_strobe = i;
        n_strobe++;
      end
      if (tot_valid) begin
        n_tot++; last_tot = tot_clocks; tot_idx = i;
      end
      sample_in = (i < plen) ? 16'(pat[i]) : 16'd0;
    end
    total_events += n_strobe;
  endtask

  task automatic t_reset();
    check(event_count == 0, "R9 count after reset", event_count, 0);
    check(!event_strobe, "R9 strobe after reset", event_strobe, 0);
    check(!tot_valid, "R9 tot_valid after reset", tot_valid, 0);
  endtask

  task automatic t_single();
    int v[11] = '{0, 200, 400, 600, 800, 1000, 800, 600, 400, 200, 0};
    thresh = 100; hyst = 50;
    plen = 11;
    foreach (v[k]) pat[k] = v[k];
    run_pattern();
    check(n_strobe == 1, "R2 single pulse strobes", n_strobe, 1);
    check(first_strobe == 8, "R2 strobe cycle", first_strobe, 8);
    check(n_tot == 1, "R6 single pulse reports", n_tot, 1);
    check(last_tot == 9, "R6 duration", last_tot, 9);
    check(tot_idx == 12, "R6 report cycle", tot_idx, 12);
    check(event_count == 32'(total_events), "R8 count", event_count, total_events);
  endtask

  task automatic t_subthresh();
    int v[5] = '{0, 50, 100, 50, 0};
    thresh = 100; hyst = 20;
    plen = 5;
    foreach (v[k]) pat[k] = v[k];
    run_pattern();
    check(n_strobe == 0, "R1 equal to threshold strobes", n_strobe, 0);
    check(n_tot == 0, "R1 equal to threshold reports", n_tot, 0);
  endtask

  task automatic t_two_peaks();
    int v[11] = '{0, 300, 600, 900, 700, 500, 700, 900, 600, 300, 0};
    thresh = 100; hyst = 100;
    plen = 11;
    foreach (v[k]) pat[k] = v[k];
    run_pattern();
    check(n_strobe == 2, "R3 overlapped distinct peaks", n_strobe, 2);
    check(first_strobe == 6, "R3 first strobe cycle", first_strobe, 6);
    check(second_strobe == 10, "R3 second strobe cycle", second_strobe, 10);
    check(n_tot == 1 && last_tot == 9, "R6 duration over two peaks", last_tot, 9);
    check(event_count == 32'(total_events), "R8 count", event_count, total_events);
  endtask

  task automatic t_merged();
    int v[9] = '{0, 300, 600, 900, 850, 900, 600, 300, 0};
    thresh = 100; hyst = 100;
    plen = 9;
    foreach (v[k]) pat[k] = v[k];
    run_pattern();
    check(n_strobe == 1, "R4 shallow dip merges", n_strobe, 1);
    check(first_strobe == 8, "R4 merged strobe cycle", first_strobe, 8);
  endtask

  task automatic t_low_pulse();
    int v[5] = '{0, 150, 250, 150, 0};
    thresh = 100; hyst = 200;
    plen = 5;
    foreach (v[k]) pat[k] = v[k];
    run_pattern();
    check(n_strobe == 1, "R5 low pulse strobes", n_strobe, 1);
    check(first_strobe == 6, "R5 strobe at threshold exit", first_strobe, 6);
    check(last_tot == 3, "R6 low pulse duration", last_tot, 3);
  endtask

  task automatic t_saturate();
    thresh = 100; hyst = 50;
    plen = 302;
    pat[0] = 0;
    for (int k = 1; k <= 300; k++) pat[k] = 500;
    pat[301] = 0;
    run_pattern();
    check(n_tot == 1 && last_tot == 255, "R7 saturated duration", last_tot, 255);
    check(n_strobe == 1, "R5 plateau strobes", n_strobe, 1);
    check(event_count == 32'(total_events), "R8 count", event_count, total_events);
  endtask

  task automatic t_reset_mid();
    thresh = 100; hyst = 50;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); sample_in = 16'd500;
    end
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(event_count == 0, "R9 count cleared mid pulse", event_count, 0);
    check(!tot_valid, "R9 no report at reset", tot_valid, 0);
    total_events = 0;
    plen = 4;
    pat[0] = 500; pat[1] = 500; pat[2] = 500; pat[3] = 0;
    run_pattern();
    check(n_tot == 1 && last_tot == 4, "R9 duration restarts", last_tot, 4);
    check(event_count == 1, "R9 count after restart", event_count, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_subthresh();
    t_two_peaks();
    t_merged();
    t_low_pulse();
    t_saturate();
    t_reset_mid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule